// File: doc/BRIEF.md
# Board Configuration and Status Register Block

This block is a bank of 32-bit registers on a simple single-cycle register bus. It drives a memory remap select and a row of user LEDs. It reports the state of user switches and the board revision, and it reports per-DLL lock state. Software can mask individual DLLs out of a single "all locked" summary bit. Two read-only words identify the build and the block.

The block also acts as the launch point for configuration transactions to an external configuration agent. Software first loads an outgoing data word. It then writes a control word that names a device, a function and a direction, with its launch bit set. The block emits a one-cycle request to the agent. When the agent signals completion, the block latches completion and error flags into a status word. On a read transaction it also captures the agent's returned data.

Top module: `board_cfg_regs`

## Requirements
- R1: After reset every writable register reads zero. `remap_o`, `led_o`, `cfg_req_o` and `bus_rvalid` are low, and the status word reads 0.
- R2: A read request (`bus_req`=1, `bus_wr`=0) returns `bus_rdata` with `bus_rvalid`=1 in the cycle after the request. `bus_rvalid` is low in every other cycle. An address outside the map, including an unaligned one, reads 0. Writes to read-only words change nothing.
- R3: Bit 0 of offset 0x000 drives `remap_o`. Bits [7:0] of offset 0x004 drive `led_o`. Both read back with all other bits 0.
- R4: Offset 0x00C returns `sw_i` in bits [7:0]. Offset 0x010 returns `board_rev_i` in bits [3:0], where 0 means revision A and 1 means B. Both words are read-only.
- R5: The control word at 0x0A8 stores launch in bit 31, direction in bit 30 (1 = write to the agent), function in [25:20] and device in [11:0]. All other bits read 0. Direction, function and device drive `cfg_write_o`, `cfg_func_o` and `cfg_dev_o`. A control write with bit 31 clear raises no request.
- R6: A control write with bit 31 set raises `cfg_req_o` for exactly one cycle, the cycle after the write. The same write clears both status flags.
- R7: While launch is set, `cfg_done_i` sets status bit 0 (complete), loads status bit 1 (error) from `cfg_err_i`, and clears launch. While launch is clear, `cfg_done_i` is ignored.
- R8: On completion of a read transaction (bit 30 = 0), `cfg_rdata_i` is captured into the return word at 0x0A0. A write transaction leaves 0x0A0 unchanged. Software may also write 0x0A0.
- R9: The outgoing data word at 0x0A4 is read/write and drives `cfg_wdata_o`.
- R10: At offset 0x100, bits [31:24] are a writable mask, bits [23:16] show `dll_locked_i` (one register stage late), and bit 0 is 1 when every DLL whose mask bit is 0 is locked.
- R11: With default parameters, offset 0xFF8 reads {8'h11, `board_rev_i`, 9'b0, 3'b111, 8'h05}. Offset 0xFFC reads 32'h5A24_2C71, where field [19:16] = 4'h4 names the bus type. Both words are read-only.
- R12: Bits [1:0] of the status word at 0x0AC may be written by software. A completion event in the same cycle takes priority over the software write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| bus_rvalid | output | 1 | Read data valid |
| remap_o | output | 1 | Memory remap select |
| led_o | output | 8 | User LEDs |
| sw_i | input | 8 | User switches |
| board_rev_i | input | 4 | Board revision |
| cfg_req_o | output | 1 | One-cycle request to configuration agent |
| cfg_write_o | output | 1 | Transaction direction, 1 = write |
| cfg_func_o | output | 6 | Function value |
| cfg_dev_o | output | 12 | Device number |
| cfg_wdata_o | output | 32 | Outgoing data |
| cfg_done_i | input | 1 | Agent completion strobe |
| cfg_err_i | input | 1 | Agent error, valid with done |
| cfg_rdata_i | input | 32 | Agent returned data, valid with done |
| dll_locked_i | input | 8 | Per-DLL lock state |

## Verification
A read result lands on `bus_rdata` one clock edge after the request. The bench queues the expected word when it issues the read, and a monitor pops and compares the word on the first falling edge at which `bus_rvalid` is high. Register writes, the request pulse and a completion strobe take effect at the single rising edge that captures them. The bench therefore checks `remap_o`, `led_o`, the agent pins and `cfg_req_o` on the falling edge right after that edge, and checks `cfg_req_o` again one cycle later for its fall. DLL lock inputs pass through one input register before the read register, so the bench waits two edges after changing them before it reads offset 0x100.

// File: rtl/board_cfg_pkg.sv
package board_cfg_pkg;

  localparam int ADDR_W = 12;
  localparam int WORD_W = 32;

  // register byte offsets
  localparam logic [ADDR_W-1:0] OFS_REMAP = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_LED   = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_SW    = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_REV   = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_RTN   = 12'h0A0;
  localparam logic [ADDR_W-1:0] OFS_DOUT  = 12'h0A4;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 12'h0A8;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 12'h0AC;
  localparam logic [ADDR_W-1:0] OFS_DLL   = 12'h100;
  localparam logic [ADDR_W-1:0] OFS_AID   = 12'hFF8;
  localparam logic [ADDR_W-1:0] OFS_ID    = 12'hFFC;

  // control word fields
  localparam int CTL_GO     = 31;
  localparam int CTL_DIR    = 30;
  localparam int CTL_FN_LO  = 20;
  localparam int CTL_FN_W   = 6;
  localparam int CTL_DEV_W  = 12;

  // lock word fields
  localparam int DLL_MASK_LO = 24;
  localparam int DLL_LOCK_LO = 16;
  localparam int DLL_SLOT_W  = 8;

  function automatic logic addr_mapped(input logic [ADDR_W-1:0] a);
    case (a)
      OFS_REMAP, OFS_LED, OFS_SW, OFS_REV, OFS_RTN, OFS_DOUT,
      OFS_CTRL, OFS_STAT, OFS_DLL, OFS_AID, OFS_ID: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/bcr_lock_reduce.sv
module bcr_lock_reduce #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mask_we,
  input  logic [N-1:0] mask_in,
  input  logic [N-1:0] lock_in,
  output logic [N-1:0] mask_q,
  output logic [N-1:0] lock_q,
  output logic         all_locked
);

  logic [N-1:0] covered;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      lock_q <= '0;
    end else begin
      lock_q <= lock_in;
      if (mask_we) mask_q <= mask_in;
    end
  end

  // a set mask bit forces that lane to count as locked
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_lane
      assign covered[g] = lock_q[g] | mask_q[g];
    end
  endgenerate

  assign all_locked = &covered;

endmodule

// File: rtl/bcr_cfg_xact.sv
module bcr_cfg_xact
  import board_cfg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ctrl_we,
  input  logic                 stat_we,
  input  logic                 dout_we,
  input  logic                 rtn_we,
  input  logic [WORD_W-1:0]    wdata,
  input  logic                 agent_done,
  input  logic                 agent_err,
  input  logic [WORD_W-1:0]    agent_rdata,
  output logic [WORD_W-1:0]    ctrl_word,
  output logic [WORD_W-1:0]    stat_word,
  output logic [WORD_W-1:0]    dout_word,
  output logic [WORD_W-1:0]    rtn_word,
  output logic                 req_pulse,
  output logic                 op_write,
  output logic [CTL_FN_W-1:0]  func,
  output logic [CTL_DEV_W-1:0] dev
);

  logic                 go_q;
  logic                 dir_q;
  logic [CTL_FN_W-1:0]  fn_q;
  logic [CTL_DEV_W-1:0] dev_q;
  logic                 cmpl_q;
  logic                 err_q;
  logic [WORD_W-1:0]    dout_q;
  logic [WORD_W-1:0]    rtn_q;
  logic                 req_q;
  logic                 launch;
  logic                 finish;

  assign launch = ctrl_we && wdata[CTL_GO];
  assign finish = go_q && agent_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      go_q   <= 1'b0;
      dir_q  <= 1'b0;
      fn_q   <= '0;
      dev_q  <= '0;
      cmpl_q <= 1'b0;
      err_q  <= 1'b0;
      dout_q <= '0;
      rtn_q  <= '0;
      req_q  <= 1'b0;
    end else begin
      req_q <= launch;

      if (ctrl_we) begin
        go_q  <= wdata[CTL_GO];
        dir_q <= wdata[CTL_DIR];
        fn_q  <= wdata[CTL_FN_LO +: CTL_FN_W];
        dev_q <= wdata[CTL_DEV_W-1:0];
      end else if (finish) begin
        go_q <= 1'b0;
      end

      if (launch) begin
        cmpl_q <= 1'b0;
        err_q  <= 1'b0;
      end else if (finish) begin
        cmpl_q <= 1'b1;
        err_q  <= agent_err;
      end else if (stat_we) begin
        cmpl_q <= wdata[0];
        err_q  <= wdata[1];
      end

      if (dout_we) dout_q <= wdata;

      if (finish && !dir_q) rtn_q <= agent_rdata;
      else if (rtn_we)      rtn_q <= wdata;
    end
  end

  always_comb begin
    ctrl_word                          = '0;
    ctrl_word[CTL_GO]                  = go_q;
    ctrl_word[CTL_DIR]                 = dir_q;
    ctrl_word[CTL_FN_LO +: CTL_FN_W]   = fn_q;
    ctrl_word[CTL_DEV_W-1:0]           = dev_q;
    stat_word                          = '0;
    stat_word[0]                       = cmpl_q;
    stat_word[1]                       = err_q;
  end

  assign dout_word = dout_q;
  assign rtn_word  = rtn_q;
  assign req_pulse = req_q;
  assign op_write  = dir_q;
  assign func      = fn_q;
  assign dev       = dev_q;

endmodule

// File: rtl/bcr_rd_port.sv
module bcr_rd_port
  import board_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [WORD_W-1:0] rd_word,
  output logic [WORD_W-1:0] rdata,
  output logic              rvalid
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= rd_word;
    end
  end

endmodule

// File: rtl/board_cfg_regs.sv
module board_cfg_regs
  import board_cfg_pkg::*;
#(
  parameter int          LED_W     = 8,
  parameter int          SW_W      = 8,
  parameter int          REV_W     = 4,
  parameter int          DLL_N     = 8,
  parameter logic [7:0]  BUILD_NUM = 8'h11,
  parameter logic [7:0]  CFG_COUNT = 8'h05,
  parameter logic [7:0]  IMPL_CODE = 8'h5A,
  parameter logic [3:0]  VARIANT   = 4'h2,
  parameter logic [3:0]  BUS_KIND  = 4'h4,
  parameter logic [11:0] PART_NUM  = 12'h2C7,
  parameter logic [3:0]  IP_REV    = 4'h1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_req,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [WORD_W-1:0]    bus_wdata,
  output logic [WORD_W-1:0]    bus_rdata,
  output logic                 bus_rvalid,
  output logic                 remap_o,
  output logic [LED_W-1:0]     led_o,
  input  logic [SW_W-1:0]      sw_i,
  input  logic [REV_W-1:0]     board_rev_i,
  output logic                 cfg_req_o,
  output logic                 cfg_write_o,
  output logic [CTL_FN_W-1:0]  cfg_func_o,
  output logic [CTL_DEV_W-1:0] cfg_dev_o,
  output logic [WORD_W-1:0]    cfg_wdata_o,
  input  logic                 cfg_done_i,
  input  logic                 cfg_err_i,
  input  logic [WORD_W-1:0]    cfg_rdata_i,
  input  logic [DLL_N-1:0]     dll_locked_i
);

  localparam int REV_SLOT_LO = 20;

  logic wr_en, rd_en;
  logic we_remap, we_led, we_ctrl, we_stat, we_dout, we_rtn, we_dll;
  logic remap_q;
  logic [LED_W-1:0] led_q;
  logic [WORD_W-1:0] ctrl_w, stat_w, dout_w, rtn_w, rd_mux;
  logic [DLL_N-1:0] dll_mask, dll_lock;
  logic dll_all;

  assign wr_en    = bus_req && bus_wr;
  assign rd_en    = bus_req && !bus_wr;
  assign we_remap = wr_en && (bus_addr == OFS_REMAP);
  assign we_led   = wr_en && (bus_addr == OFS_LED);
  assign we_ctrl  = wr_en && (bus_addr == OFS_CTRL);
  assign we_stat  = wr_en && (bus_addr == OFS_STAT);
  assign we_dout  = wr_en && (bus_addr == OFS_DOUT);
  assign we_rtn   = wr_en && (bus_addr == OFS_RTN);
  assign we_dll   = wr_en && (bus_addr == OFS_DLL);

  always_ff @(posedge clk) begin
    if (rst) begin
      remap_q <= 1'b0;
      led_q   <= '0;
    end else begin
      if (we_remap) remap_q <= bus_wdata[0];
      if (we_led)   led_q   <= bus_wdata[LED_W-1:0];
    end
  end

  assign remap_o = remap_q;
  assign led_o   = led_q;

  bcr_cfg_xact u_xact (
    .clk         (clk),
    .rst         (rst),
    .ctrl_we     (we_ctrl),
    .stat_we     (we_stat),
    .dout_we     (we_dout),
    .rtn_we      (we_rtn),
    .wdata       (bus_wdata),
    .agent_done  (cfg_done_i),
    .agent_err   (cfg_err_i),
    .agent_rdata (cfg_rdata_i),
    .ctrl_word   (ctrl_w),
    .stat_word   (stat_w),
    .dout_word   (dout_w),
    .rtn_word    (rtn_w),
    .req_pulse   (cfg_req_o),
    .op_write    (cfg_write_o),
    .func        (cfg_func_o),
    .dev         (cfg_dev_o)
  );

  assign cfg_wdata_o = dout_w;

  bcr_lock_reduce #(.N(DLL_N)) u_lock (
    .clk        (clk),
    .rst        (rst),
    .mask_we    (we_dll),
    .mask_in    (bus_wdata[DLL_MASK_LO +: DLL_N]),
    .lock_in    (dll_locked_i),
    .mask_q     (dll_mask),
    .lock_q     (dll_lock),
    .all_locked (dll_all)
  );

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      OFS_REMAP: rd_mux[0] = remap_q;
      OFS_LED:   rd_mux[LED_W-1:0] = led_q;
      OFS_SW:    rd_mux[SW_W-1:0] = sw_i;
      OFS_REV:   rd_mux[REV_W-1:0] = board_rev_i;
      OFS_RTN:   rd_mux = rtn_w;
      OFS_DOUT:  rd_mux = dout_w;
      OFS_CTRL:  rd_mux = ctrl_w;
      OFS_STAT:  rd_mux = stat_w;
      OFS_DLL: begin
        rd_mux[DLL_MASK_LO +: DLL_N] = dll_mask;
        rd_mux[DLL_LOCK_LO +: DLL_N] = dll_lock;
        rd_mux[0]                    = dll_all;
      end
      OFS_AID: begin
        rd_mux[31:24]                     = BUILD_NUM;
        rd_mux[REV_SLOT_LO +: REV_W]      = board_rev_i;
        rd_mux[10:8]                      = 3'b111;
        rd_mux[7:0]                       = CFG_COUNT;
      end
      OFS_ID:    rd_mux = {IMPL_CODE, VARIANT, BUS_KIND, PART_NUM, IP_REV};
      default:   rd_mux = '0;
    endcase
  end

  bcr_rd_port u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .rd_word (rd_mux),
    .rdata   (bus_rdata),
    .rvalid  (bus_rvalid)
  );

endmodule

// File: rtl/board_cfg_chk.sv
module board_cfg_chk
  import board_cfg_pkg::*;
#(
  parameter int LED_W = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 bus_req,
  input logic                 bus_wr,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [WORD_W-1:0]    bus_wdata,
  input logic [WORD_W-1:0]    bus_rdata,
  input logic                 bus_rvalid,
  input logic                 remap_o,
  input logic [LED_W-1:0]     led_o,
  input logic                 cfg_req_o,
  input logic [CTL_FN_W-1:0]  cfg_func_o,
  input logic [CTL_DEV_W-1:0] cfg_dev_o,
  input logic [WORD_W-1:0]    cfg_wdata_o
);

  logic rd_go, ctl_wr, go_wr;
  assign rd_go  = bus_req && !bus_wr;
  assign ctl_wr = bus_req && bus_wr && (bus_addr == OFS_CTRL);
  assign go_wr  = ctl_wr && bus_wdata[CTL_GO];

  assert_rvalid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    rd_go |=> bus_rvalid);

  assert_no_stray_rvalid_R2: assert property (@(posedge clk) disable iff (rst)
    !rd_go |=> !bus_rvalid);

  assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_go && !addr_mapped(bus_addr)) |=> (bus_rdata == '0));

  assert_remap_write_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_wr && bus_addr == OFS_REMAP) |=> (remap_o == $past(bus_wdata[0])));

  assert_led_write_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_wr && bus_addr == OFS_LED) |=> (led_o == $past(bus_wdata[LED_W-1:0])));

  assert_agent_fields_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !ctl_wr |=> ($stable(cfg_func_o) && $stable(cfg_dev_o)));

  assert_req_has_cause_R6: assert property (@(posedge clk) disable iff (rst)
    cfg_req_o |-> $past(go_wr));

  assert_req_after_go_R6: assert property (@(posedge clk) disable iff (rst)
    go_wr |=> cfg_req_o);

  assert_dout_write_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_wr && bus_addr == OFS_DOUT) |=> (cfg_wdata_o == $past(bus_wdata)));

endmodule

bind board_cfg_regs board_cfg_chk #(.LED_W(LED_W)) u_chk (.*);

// File: tb/sim_board_cfg_regs.sv
`timescale 1ns/1ps
module sim_board_cfg_regs;

  logic        clk = 1'b0;
  logic        rst;
  logic        bus_req, bus_wr;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        bus_rvalid, remap_o;
  logic [7:0]  led_o, sw_i;
  logic [3:0]  board_rev_i;
  logic        cfg_req_o, cfg_write_o;
  logic [5:0]  cfg_func_o;
  logic [11:0] cfg_dev_o;
  logic [31:0] cfg_wdata_o;
  logic        cfg_done_i, cfg_err_i;
  logic [31:0] cfg_rdata_i;
  logic [7:0]  dll_locked_i;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } sb_item_t;
  sb_item_t sbq[$];

  always #2 clk = ~clk;

  board_cfg_regs u0 (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per returned read
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (sbq.size() == 0) begin
        n_run++; n_fail++;
        $display("FAIL R2: unexpected rvalid, actual %08h expected none", bus_rdata);
      end else begin
        sb_item_t it;
        it = sbq.pop_front();
        check(it.tag, bus_rdata, it.exp);
      end
    end
  end

  task automatic bwrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bread(input logic [11:0] a, input logic [31:0] e, input string tag);
    sb_item_t it;
    @(negedge clk);
    it.exp = e; it.tag = tag;
    sbq.push_back(it);
    bus_req = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0;
  endtask

  task automatic agent_done(input logic err, input logic [31:0] rd);
    @(negedge clk);
    cfg_done_i = 1'b1; cfg_err_i = err; cfg_rdata_i = rd;
    @(negedge clk);
    cfg_done_i = 1'b0; cfg_err_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; bus_req = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    sw_i = '0; board_rev_i = '0; cfg_done_i = 0; cfg_err_i = 0;
    cfg_rdata_i = '0; dll_locked_i = '0;
    repeat (5) @(negedge clk);
    // R1 reset state
    check("R1 remap", {31'b0, remap_o}, 0);
    check("R1 led", {24'b0, led_o}, 0);
    check("R1 req", {31'b0, cfg_req_o}, 0);
    check("R1 rvalid", {31'b0, bus_rvalid}, 0);
    rst = 1'b0;
    bread(12'h0A8, 32'h0, "R1 ctrl");
    bread(12'h0AC, 32'h0, "R1 stat");
    bread(12'h0A4, 32'h0, "R1 dout");
    bread(12'h0A0, 32'h0, "R1 rtn");
    bread(12'h100, 32'h0, "R1 dll");

    // R3 remap and LEDs
    bwrite(12'h000, 32'h0000_0001);
    check("R3 remap pin", {31'b0, remap_o}, 1);
    bread(12'h000, 32'h1, "R3 remap read");
    bwrite(12'h000, 32'hFFFF_FFFE);
    check("R3 remap clear", {31'b0, remap_o}, 0);
    bwrite(12'h004, 32'hABCD_12A5);
    check("R3 led pin", {24'b0, led_o}, 32'hA5);
    bread(12'h004, 32'hA5, "R3 led read");

    // R4 switches and revision, R2 read-only
    sw_i = 8'h3C; board_rev_i = 4'h1;
    bread(12'h00C, 32'h3C, "R4 sw");
    bread(12'h010, 32'h1, "R4 rev");
    bwrite(12'h00C, 32'hFF);
    bwrite(12'h010, 32'hF);
    bread(12'h00C, 32'h3C, "R2 sw readonly");
    bread(12'h010, 32'h1, "R2 rev readonly");
    sw_i = 8'hC3;
    bread(12'h00C, 32'hC3, "R4 sw change");

    // R2 unmapped
    bread(12'h008, 32'h0, "R2 hole 008");
    bread(12'h0FC, 32'h0, "R2 hole 0FC");
    bread(12'h101, 32'h0, "R2 unaligned");

    // R9 data out
    bwrite(12'h0A4, 32'hDEAD_BEEF);
    check("R9 wdata pin", cfg_wdata_o, 32'hDEAD_BEEF);
    bread(12'h0A4, 32'hDEAD_BEEF, "R9 dout read");

    // R5 control fields, no launch
    bwrite(12'h0A8, 32'h7FFF_FFFF);
    check("R5 no req", {31'b0, cfg_req_o}, 0);
    check("R5 dir pin", {31'b0, cfg_write_o}, 1);
    check("R5 func pin", {26'b0, cfg_func_o}, 32'h3F);
    check("R5 dev pin", {20'b0, cfg_dev_o}, 32'hFFF);
    bread(12'h0A8, 32'h43F0_0FFF, "R5 ctrl read");

    // R12 status software write
    bwrite(12'h0AC, 32'hFFFF_FFFF);
    bread(12'h0AC, 32'h3, "R12 stat write");

    // R6 launch read transaction
    bwrite(12'h0A8, 32'h8050_0002);
    check("R6 req high", {31'b0, cfg_req_o}, 1);
    @(negedge clk);
    check("R6 req one cycle", {31'b0, cfg_req_o}, 0);
    bread(12'h0AC, 32'h0, "R6 stat cleared");
    bread(12'h0A8, 32'h8050_0002, "R6 ctrl busy");

    // R7 and R8 completion of read
    agent_done(1'b0, 32'h1234_5678);
    bread(12'h0AC, 32'h1, "R7 complete");
    bread(12'h0A8, 32'h0050_0002, "R7 go cleared");
    bread(12'h0A0, 32'h1234_5678, "R8 rtn captured");

    // R7 done while idle is ignored
    agent_done(1'b1, 32'hFFFF_0000);
    bread(12'h0AC, 32'h1, "R7 idle done ignored");
    bread(12'h0A0, 32'h1234_5678, "R8 idle rtn kept");

    // write transaction with error
    bwrite(12'h0A8, 32'hC010_0001);
    check("R6 req write op", {31'b0, cfg_req_o}, 1);
    agent_done(1'b1, 32'hAAAA_5555);
    bread(12'h0AC, 32'h3, "R7 error flag");
    bread(12'h0A8, 32'h4010_0001, "R7 go cleared wr");
    bread(12'h0A0, 32'h1234_5678, "R8 write op no capture");
    bwrite(12'h0A0, 32'h0BAD_F00D);
    bread(12'h0A0, 32'h0BAD_F00D, "R8 rtn sw write");

    // R10 DLL lock and mask
    dll_locked_i = 8'hF0;
    repeat (2) @(negedge clk);
    bread(12'h100, 32'h00F0_0000, "R10 partial lock");
    bwrite(12'h100, 32'h0F00_0000);
    bread(12'h100, 32'h0FF0_0001, "R10 masked all");
    dll_locked_i = 8'hE0;
    repeat (2) @(negedge clk);
    bread(12'h100, 32'h0FE0_0000, "R10 unmasked drop");
    bwrite(12'h100, 32'h1F00_0000);
    bread(12'h100, 32'h1FE0_0001, "R10 remask");
    dll_locked_i = 8'hFF;
    bwrite(12'h100, 32'h0);
    repeat (2) @(negedge clk);
    bread(12'h100, 32'h00FF_0001, "R10 all locked");

    // R11 identification
    board_rev_i = 4'h1;
    bread(12'hFF8, 32'h1110_0705, "R11 aid rev1");
    bread(12'hFFC, 32'h5A24_2C71, "R11 id");
    board_rev_i = 4'h2;
    bwrite(12'hFFC, 32'h0);
    bread(12'hFF8, 32'h1120_0705, "R11 aid rev2");
    bread(12'hFFC, 32'h5A24_2C71, "R11 id readonly");

    repeat (3) @(negedge clk);
    if (sbq.size() != 0) begin
      n_run++; n_fail++;
      $display("FAIL R2: missing reads, actual %0d pending expected 0", sbq.size());
    end
    finish_run();
  end

endmodule